// File: doc/BRIEF.md
# UART Receive Character Queue

This block sits between a UART receive shifter and the host-visible register interface. Each completed character arrives from the shifter together with the value sampled for its first stop bit. The block keeps up to two unread characters in arrival order. Each stored entry carries its own frame-error and overrun status, so the status the host sees always belongs to the character it will read next.

The host sees the oldest character on a shared data port and reads it with a one-cycle strobe. That strobe also advances the queue. The status byte reports three things: whether unread data is present, whether the head character had a framing error, and whether characters were lost behind it. A character size setting selects 5, 6, 7 or 8 data bits, and unused upper bits are stored as zero. Clearing the receiver enable empties the queue at once.

Characters enter over a valid/ready stream. Ready follows the receiver enable and nothing else. While the receiver is enabled, every offered character is taken in the cycle it is offered. When the queue is full and no read happens in the same cycle, the character is dropped and the overrun mark is placed on the newest stored entry. While the receiver is disabled, ready is low and offered characters are neither stored nor counted as lost.

Top module: `uart_rx_fifo2`

## Requirements
- R1: Reads return characters in arrival order. `rd_data` shows the head character, and a cycle with `host_rd` high and the queue non-empty removes that head. When the queue is empty, `rd_data` is 0 and `host_rd` has no effect.
- R2: `status_byte[7]` is 1 exactly while the queue holds at least one unread character. It is 0 after reset.
- R3: While `rx_en` is 0 at a rising clock edge, the queue is emptied at that edge and `status_byte[7]` reads 0 afterwards. A character offered in that cycle is not stored.
- R4: `status_byte[4]` is 1 when the head character's stop bit (`in_stop`) was captured as 0. It is 0 when that stop bit was 1. It changes only when the head changes.
- R5: `char_size` gives the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. The setting in force at capture applies, and bits at or above that width are stored and read as 0.
- R6: A character offered while two entries are stored and no read happens in the same cycle is dropped. The newest stored entry gets its overrun mark, and `status_byte[3]` reports that mark once that entry reaches the head. An entry stored normally has the mark clear.
- R7: A push and a valid read in the same cycle are both carried out, including when the queue is full. The occupancy is unchanged and no overrun is marked.
- R8: `irq` is 1 exactly while `status_byte[7]` and `irq_en` are both 1.
- R9: `status_byte` bits 6, 5, 2, 1 and 0 always read 0. Bits 4 and 3 read 0 while the queue is empty.
- R10: `in_ready` equals `rx_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; 0 flushes the queue |
| char_size | input | 2 | Data bits per character: 0=5, 1=6, 2=7, 3=8 |
| in_valid | input | 1 | Shifter offers a completed character |
| in_ready | output | 1 | Block accepts a character (follows rx_en) |
| in_char | input | 8 | Received character bits, LSB first bit |
| in_stop | input | 1 | Sampled value of the first stop bit |
| host_rd | input | 1 | Host read strobe for the data port; pops the head |
| irq_en | input | 1 | Receive-complete interrupt enable |
| rd_data | output | 8 | Head character, zero-filled above the size |
| status_byte | output | 8 | bit7 data present, bit4 frame error, bit3 overrun |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The assertions assume that `host_rd` is a single-cycle strobe for each intended read, so a strobe held high drains one entry per cycle. They also assume that `char_size` is held steady in any cycle where a character is offered. The bench changes every input only on the falling edge, so both conditions hold at each sampling edge. It mixes random offers, reads and enable drops with directed sequences: a full queue that overruns, a push that lands in the same cycle as a read on a full queue, a flush while a character is offered, and a masking test for each size.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned RXQ_DATA_W = 8;

  typedef enum logic [1:0] {
    CSZ_5 = 2'd0,
    CSZ_6 = 2'd1,
    CSZ_7 = 2'd2,
    CSZ_8 = 2'd3
  } char_size_e;

  typedef struct packed {
    logic [RXQ_DATA_W-1:0] data;
    logic                  ferr;
    logic                  ovr;
  } rx_entry_t;

endpackage

// File: rtl/rx_char_mask.sv
module rx_char_mask #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MIN_W  = 5,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [SIZE_W-1:0] size_code,
  output logic [DATA_W-1:0] masked
);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (g < MIN_W) begin : g_always
      assign masked[g] = raw[g];
    end else begin : g_sized
      assign masked[g] = raw[g] && (int'(size_code) > (g - int'(MIN_W)));
    end
  end

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop_req,
  output rx_entry_t head_entry,
  output logic      not_empty
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             pop_ok;
  logic             push_ok;
  logic             ovr_mark;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] newest_idx;
  logic [DEPTH-1:0] slot_wr;
  logic [DEPTH-1:0] slot_ovr;

  function automatic logic [PTR_W-1:0] wrap(input int unsigned v);
    return PTR_W'(v % DEPTH);
  endfunction

  assign full       = (count == CNT_W'(DEPTH));
  assign not_empty  = (count != '0);
  assign pop_ok     = pop_req && not_empty;
  assign push_ok    = push && (!full || pop_ok);
  assign ovr_mark   = push && full && !pop_ok;
  assign wr_idx     = wrap(int'(head) + int'(count));
  assign newest_idx = wrap(int'(head) + int'(count) + DEPTH - 1);
  assign head_entry = mem[head];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_wr[g]  = !flush && push_ok  && (wr_idx == PTR_W'(g));
    assign slot_ovr[g] = !flush && ovr_mark && (newest_idx == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_wr[i])       mem[i]     <= push_entry;
        else if (slot_ovr[i]) mem[i].ovr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (pop_ok) head <= wrap(int'(head) + 1);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  // R1: occupancy never exceeds the depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R1: a lone read removes one entry
  p_pop_advances_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push && !flush) |=> (count == $past(count) - 1'b1));

  // R3: disable empties the queue
  p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !not_empty);

  // R6: a dropped character leaves occupancy and head unchanged
  p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mark && !flush) |=> (full && $stable(head) && head_entry.data == $past(head_entry.data)));

  // R7: push with read keeps occupancy
  p_pushpop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_ok && !flush) |=> $stable(count));

endmodule

// File: rtl/rx_status_pack.sv
module rx_status_pack
  import uart_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  not_empty,
  input  rx_entry_t             head_entry,
  input  logic                  irq_en,
  output logic [RXQ_DATA_W-1:0] rd_data,
  output logic [7:0]            status_byte,
  output logic                  irq
);

  localparam int unsigned BIT_RXC = 7;
  localparam int unsigned BIT_FE  = 4;
  localparam int unsigned BIT_DOR = 3;

  always_comb begin
    status_byte          = '0;
    status_byte[BIT_RXC] = not_empty;
    status_byte[BIT_FE]  = not_empty && head_entry.ferr;
    status_byte[BIT_DOR] = not_empty && head_entry.ovr;
    rd_data              = not_empty ? head_entry.data : '0;
  end

  assign irq = status_byte[BIT_RXC] && irq_en;

  // R9: an empty queue shows no data and no error status
  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !status_byte[BIT_RXC] |-> (rd_data == '0 && status_byte == '0));

  // R8: interrupt request only with data present
  p_irq_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_byte[BIT_RXC] && irq_en));

endmodule

// File: rtl/uart_rx_fifo2.sv
module uart_rx_fifo2
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic [1:0] char_size,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_char,
  input  logic       in_stop,
  input  logic       host_rd,
  input  logic       irq_en,
  output logic [7:0] rd_data,
  output logic [7:0] status_byte,
  output logic       irq
);

  logic [RXQ_DATA_W-1:0] masked_char;
  rx_entry_t             push_entry;
  rx_entry_t             head_entry;
  logic                  not_empty;
  logic                  push;

  assign in_ready = rx_en;
  assign push     = in_valid && in_ready;

  rx_char_mask #(
    .DATA_W (RXQ_DATA_W),
    .MIN_W  (5),
    .SIZE_W (2)
  ) u_mask (
    .raw       (in_char),
    .size_code (char_size),
    .masked    (masked_char)
  );

  always_comb begin
    push_entry.data = masked_char;
    push_entry.ferr = !in_stop;
    push_entry.ovr  = 1'b0;
  end

  rx_char_queue #(
    .DEPTH (DEPTH)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (!rx_en),
    .push       (push),
    .push_entry (push_entry),
    .pop_req    (host_rd),
    .head_entry (head_entry),
    .not_empty  (not_empty)
  );

  rx_status_pack u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .not_empty   (not_empty),
    .head_entry  (head_entry),
    .irq_en      (irq_en),
    .rd_data     (rd_data),
    .status_byte (status_byte),
    .irq         (irq)
  );

  // R4: frame-error status holds while no read and no new head
  p_fe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !host_rd && status_byte[7]) |=> $stable(status_byte[4]));

  // R5: bits above the chosen width never reach the data port
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && in_valid && !status_byte[7] && char_size == 2'd0) |=> (rd_data[7:5] == 3'b000));

endmodule

// File: tb/uart_rx_fifo2_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo2_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en;
  logic [1:0] char_size;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_char;
  logic       in_stop;
  logic       host_rd;
  logic       irq_en;
  logic [7:0] rd_data;
  logic [7:0] status_byte;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] m_d  [2];
  bit         m_fe [2];
  bit         m_ov [2];
  int         m_cnt = 0;

  always #2.5 clk = ~clk;

  uart_rx_fifo2 u_uart_rx_fifo2 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_size(char_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
    .in_stop(in_stop), .host_rd(host_rd), .irq_en(irq_en),
    .rd_data(rd_data), .status_byte(status_byte), .irq(irq)
  );

  function automatic logic [7:0] exp_mask(input logic [7:0] d, input logic [1:0] sz);
    int w = 5 + int'(sz);
    return d & 8'((1 << w) - 1);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input bit ie);
    bit ne = (m_cnt > 0);
    chk("R2 data present", {7'd0, status_byte[7]}, {7'd0, ne});
    chk("R4 frame error",  {7'd0, status_byte[4]}, {7'd0, ne && m_fe[0]});
    chk("R6 overrun",      {7'd0, status_byte[3]}, {7'd0, ne && m_ov[0]});
    chk("R9 unused bits",  {status_byte[6:5], status_byte[2:0]}, 8'd0);
    chk("R1 head data",    rd_data, ne ? m_d[0] : 8'd0);
    chk("R8 irq",          {7'd0, irq}, {7'd0, ne && ie});
  endtask

  task automatic step(input bit en, input bit v, input logic [7:0] ch, input bit stp,
                      input bit rd, input bit ie, input logic [1:0] sz);
    bit popd;
    bit wasfull;
    rx_en = en; in_valid = v; in_char = ch; in_stop = stp;
    host_rd = rd; irq_en = ie; char_size = sz;
    #1;
    chk("R10 ready", {7'd0, in_ready}, {7'd0, en});
    @(posedge clk);
    if (!en) begin
      m_cnt = 0;
    end else begin
      popd = rd && (m_cnt > 0);
      wasfull = (m_cnt == 2);
      if (popd) begin
        m_d[0] = m_d[1]; m_fe[0] = m_fe[1]; m_ov[0] = m_ov[1];
        m_cnt--;
      end
      if (v) begin
        if (wasfull && !popd) begin
          m_ov[1] = 1'b1;
        end else begin
          m_d[m_cnt] = exp_mask(ch, sz);
          m_fe[m_cnt] = !stp;
          m_ov[m_cnt] = 1'b0;
          m_cnt++;
        end
      end
    end
    @(negedge clk);
    compare_all(ie);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_en = 1'b0; in_valid = 1'b0; in_char = 8'd0; in_stop = 1'b1;
    host_rd = 1'b0; irq_en = 1'b1; char_size = 2'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset status", status_byte, 8'h00);
    chk("R8 reset irq", {7'd0, irq}, 8'd0);

    // R5: each size masks an all-ones character
    for (int s = 0; s < 4; s++) begin
      step(1, 1, 8'hFF, 1, 0, 1, 2'(s));
      chk("R5 size mask", rd_data, exp_mask(8'hFF, 2'(s)));
      step(1, 0, 8'h00, 1, 1, 1, 2'd3);
    end

    // R6: overrun on full queue
    step(1, 1, 8'hA1, 1, 0, 0, 2'd3);
    step(1, 1, 8'hB2, 0, 0, 0, 2'd3);
    step(1, 1, 8'hC3, 1, 0, 0, 2'd3);
    chk("R6 head unmarked", {status_byte[4], status_byte[3]}, 8'd0);
    chk("R6 head kept", rd_data, 8'hA1);
    step(1, 0, 8'h00, 1, 1, 0, 2'd3);
    chk("R6 newest marked", {6'd0, status_byte[4], status_byte[3]}, 8'd3);
    chk("R6 dropped char absent", rd_data, 8'hB2);
    step(1, 0, 8'h00, 1, 1, 0, 2'd3);

    // R7: push with read on a full queue
    step(1, 1, 8'h11, 1, 0, 1, 2'd3);
    step(1, 1, 8'h22, 1, 0, 1, 2'd3);
    step(1, 1, 8'h33, 1, 1, 1, 2'd3);
    chk("R7 head after push+pop", rd_data, 8'h22);
    step(1, 0, 8'h00, 1, 1, 1, 2'd3);
    chk("R7 kept pushed char", rd_data, 8'h33);
    chk("R7 no overrun", {7'd0, status_byte[3]}, 8'd0);
    step(1, 0, 8'h00, 1, 1, 1, 2'd3);

    // R3: flush while a character is offered
    step(1, 1, 8'h5A, 1, 0, 1, 2'd3);
    step(0, 1, 8'h6B, 1, 0, 1, 2'd3);
    chk("R3 flushed", {7'd0, status_byte[7]}, 8'd0);
    step(1, 0, 8'h00, 1, 1, 1, 2'd3);
    chk("R3 offered char not stored", {7'd0, status_byte[7]}, 8'd0);

    // R1: read on empty queue has no effect
    step(1, 0, 8'h00, 1, 1, 1, 2'd3);
    chk("R1 empty read", rd_data, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 95, ($urandom % 100) < 40, 8'($urandom),
           ($urandom % 100) < 75, ($urandom % 100) < 35, 1'($urandom),
           2'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule